// File: doc/BRIEF.md
# Interrupt Status and DMA Request Unit

This unit keeps the event status, the interrupt enables and the DMA request configuration of a serial bus controller. The transfer logic raises or drops status flags through per-bit set and clear pulses. A small register port lets software read and change the unit. The unit drives one level interrupt line and two DMA request lines: one for receive, one for transmit. All three are combinational functions of the stored registers. Any change to a register therefore shows on them one clock after the edge that stores it.

A `REVISION` parameter picks one of two software models. Older revisions (below 0x34) have a read-only status register and an interrupt vector port. Reading the vector returns the lowest pending enabled event and acknowledges it. Newer revisions (0x34 and above) have no vector. They clear status by writing ones, and a test write can force all six interrupt sources on at once. Protocol timing, the data path and transfer sequencing live elsewhere.

Top module: `isd_irq_dma_unit`

## Requirements
- R1: After a clock with `rst_n` low, status, enable mask and DMA configuration are all zero, and `irq`, `dreq_rx` and `dreq_tx` are low.
- R2: A bit of `set_pulse` sets that status bit and a bit of `clr_pulse` clears it, on the next edge. When both hit the same bit in one cycle, the set wins.
- R3: When `reg_rd` is high with `reg_addr`=1, `reg_rdata` returns the stored status with bit 12 replaced by the live `bus_busy` input.
- R4: `irq` is high exactly when status AND enable mask is non-zero.
- R5: `dreq_rx` equals DMA configuration bit 15 AND status bit 3 (receive ready). `dreq_tx` equals DMA configuration bit 7 AND status bit 4 (transmit ready).
- R6: A write to `reg_addr`=3 stores only bits 15 and 7 of the data into the DMA configuration. Bit 15 set in that write clears mask bit 3, and bit 7 set clears mask bit 4. A read of address 3 returns the configuration.
- R7: A write to `reg_addr`=0 stores the data ANDed with 0x001F on older revisions and with 0x003F on newer ones. A read of address 0 returns the mask.
- R8: On older revisions, `reg_rdata` at `reg_addr`=2 during a read is one plus the index of the lowest set bit of status AND mask. That status bit is cleared on the same edge, unless a set pulse for it arrives in that cycle.
- R9: The vector read returns 0 when nothing is pending. On newer revisions it always returns 0 and changes no state. Address 4 reads as 0, and `reg_rdata` is 0 whenever `reg_rd` is low.
- R10: On newer revisions, a write to `reg_addr`=1 clears the status bits set in both the data and 0x0027. On older revisions such a write has no effect.
- R11: On newer revisions, a write to `reg_addr`=4 with data bit 11 set sets status bits 5 to 0. Without bit 11, or on older revisions, it has no effect.
- R12: `irq`, `dreq_rx` and `dreq_tx` reflect a register change in the cycle that follows the edge storing it, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; the vector read acts on it |
| reg_addr | input | 3 | Register select: 0 mask, 1 status, 2 vector, 3 DMA config, 4 test |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational, zero when no read |
| set_pulse | input | 16 | Per-bit status set pulses from transfer logic |
| clr_pulse | input | 16 | Per-bit status clear pulses from transfer logic |
| bus_busy | input | 1 | Live bus-busy flag shown in status bit 12 |
| irq | output | 1 | Interrupt request |
| dreq_rx | output | 1 | Receive DMA request |
| dreq_tx | output | 1 | Transmit DMA request |

## Verification
A wrong status bit appears on `irq` or on a DMA request one cycle after the faulty edge, provided the matching enable is set. It appears at once in a status read. A mis-kept enable bit or a stray DMA configuration bit shows in the read of address 0 or 3, and then as a missing or spurious request. An acknowledge that clears the wrong bit gives a wrong value on the next vector read. The reference model checks all outputs after every edge, so any of these faults is reported in the cycle after the edge that caused it.

// File: rtl/isd_pkg.sv
// Shared constants for the interrupt status and DMA request unit.
// Assumes a 16-bit status register; the bit positions below are fixed by
// the neighbouring transfer logic and by software.
package isd_pkg;
    typedef enum logic [2:0] {
        SEL_MASK   = 3'd0,
        SEL_STATUS = 3'd1,
        SEL_VECTOR = 3'd2,
        SEL_DMACFG = 3'd3,
        SEL_TEST   = 3'd4
    } reg_sel_e;

    localparam logic [7:0]  NEW_REV_MIN   = 8'h34;
    localparam int          RX_READY_BIT  = 3;
    localparam int          TX_READY_BIT  = 4;
    localparam int          BUSY_BIT      = 12;
    localparam int          RX_DMA_EN_BIT = 15;
    localparam int          TX_DMA_EN_BIT = 7;
    localparam int          FORCE_TRIG    = 11;
    localparam logic [15:0] W1C_BITS      = 16'h0027;
    localparam logic [15:0] FORCE_BITS    = 16'h003f;
    localparam logic [15:0] DMA_KEEP      = 16'h8080;
    localparam logic [15:0] MASK_KEEP_OLD = 16'h001f;
    localparam logic [15:0] MASK_KEEP_NEW = 16'h003f;
endpackage

// File: rtl/isd_lowest_pending.sv
// Finds the lowest set bit of a vector.
// Assumes W >= 2; idx is meaningful only while found is high.
module isd_lowest_pending #(
    parameter int W     = 16,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    // Any bit set means something is pending.
    assign found = |vec;
endmodule

// File: rtl/isd_status_reg.sv
// Status register with per-bit set and clear sources.
// Assumes the top merges all software and vector clears into sw_clr and the
// forced bits into force_set; a set in the same cycle always beats a clear.
module isd_status_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_pulse,
    input  logic [W-1:0] clr_pulse,
    input  logic [W-1:0] sw_clr,
    input  logic [W-1:0] force_set,
    output logic [W-1:0] status
);
    logic [W-1:0] status_next;

    // Clears first, then every set source ORed on top.
    always_comb begin
        status_next = (status & ~clr_pulse & ~sw_clr) | set_pulse | force_set;
    end

    // Hold the status bits, zero under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= status_next;
    end

    // R2: any pulsed set bit is present after the edge.
    a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(set_pulse)) == $past(set_pulse)));

    // R2: a clear pulse without a set or force leaves the bit low.
    a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(clr_pulse) & ~$past(set_pulse) & ~$past(force_set)) == '0));
endmodule

// File: rtl/isd_cfg_regs.sv
// Interrupt enable mask and DMA request configuration.
// Assumes at most one of wr_mask / wr_dma per cycle (they come from one
// address decode). MASK_KEEP picks the enable width for the revision.
module isd_cfg_regs
    import isd_pkg::*;
#(
    parameter int          W         = 16,
    parameter logic [15:0] MASK_KEEP = MASK_KEEP_NEW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_mask,
    input  logic         wr_dma,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask,
    output logic [W-1:0] dma_cfg
);
    logic [W-1:0] mask_next;
    logic [W-1:0] dma_next;

    // Next enable and DMA values; turning on a DMA channel drops its ready enable.
    always_comb begin
        mask_next = mask;
        dma_next  = dma_cfg;
        if (wr_mask) mask_next = wdata & W'(MASK_KEEP);
        if (wr_dma) begin
            dma_next = wdata & W'(DMA_KEEP);
            if (wdata[RX_DMA_EN_BIT]) mask_next[RX_READY_BIT] = 1'b0;
            if (wdata[TX_DMA_EN_BIT]) mask_next[TX_READY_BIT] = 1'b0;
        end
    end

    // Hold mask and DMA configuration, zero under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask    <= '0;
            dma_cfg <= '0;
        end else begin
            mask    <= mask_next;
            dma_cfg <= dma_next;
        end
    end

    // R6: enabling receive DMA leaves the receive-ready enable off.
    a_r6_rx_dma_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dma && wdata[RX_DMA_EN_BIT]) |=> !mask[RX_READY_BIT]);

    // R6: enabling transmit DMA leaves the transmit-ready enable off.
    a_r6_tx_dma_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dma && wdata[TX_DMA_EN_BIT]) |=> !mask[TX_READY_BIT]);

    // R7: a mask write keeps only the revision's enable bits.
    a_r7_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask == ($past(wdata) & W'(MASK_KEEP))));
endmodule

// File: rtl/isd_irq_dma_unit.sv
// Interrupt status and DMA request unit, top level.
// Decodes the register port, picks the revision's clear and force sources,
// and drives the interrupt and DMA request lines from stored state.
// Assumes DATA_W = 16 (bit positions come from isd_pkg) and that reg_wr and
// reg_rd are not high in the same cycle.
module isd_irq_dma_unit
    import isd_pkg::*;
#(
    parameter logic [7:0] REVISION = 8'h34,
    parameter int         DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] set_pulse,
    input  logic [DATA_W-1:0] clr_pulse,
    input  logic              bus_busy,
    output logic              irq,
    output logic              dreq_rx,
    output logic              dreq_tx
);
    localparam bit          NEW_REV   = (REVISION >= NEW_REV_MIN);
    localparam int          IDX_W     = $clog2(DATA_W);
    localparam logic [15:0] MASK_KEEP = NEW_REV ? MASK_KEEP_NEW : MASK_KEEP_OLD;

    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] dma_cfg;
    logic [DATA_W-1:0] pending;
    logic [DATA_W-1:0] sw_clr;
    logic [DATA_W-1:0] force_set;
    logic [DATA_W-1:0] vector_code;
    logic [DATA_W-1:0] status_view;
    logic              pend_any;
    logic [IDX_W-1:0]  pend_idx;
    logic              wr_mask;
    logic              wr_dma;
    logic              wr_status;

    // Address decode for the register writes.
    always_comb begin
        wr_mask   = reg_wr && (reg_addr == SEL_MASK);
        wr_dma    = reg_wr && (reg_addr == SEL_DMACFG);
        wr_status = reg_wr && (reg_addr == SEL_STATUS);
    end

    isd_status_reg #(.W(DATA_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (set_pulse),
        .clr_pulse (clr_pulse),
        .sw_clr    (sw_clr),
        .force_set (force_set),
        .status    (status)
    );

    isd_cfg_regs #(.W(DATA_W), .MASK_KEEP(MASK_KEEP)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_dma  (wr_dma),
        .wdata   (reg_wdata),
        .mask    (mask),
        .dma_cfg (dma_cfg)
    );

    // Enabled events feeding the interrupt and the vector.
    assign pending = status & mask;

    isd_lowest_pending #(.W(DATA_W), .IDX_W(IDX_W)) u_find (
        .vec   (pending),
        .found (pend_any),
        .idx   (pend_idx)
    );

    generate
        if (NEW_REV) begin : g_new
            logic wr_test;
            // Write-one-to-clear status and forced interrupts; no vector.
            always_comb begin
                wr_test     = reg_wr && (reg_addr == SEL_TEST);
                sw_clr      = wr_status ? (reg_wdata & DATA_W'(W1C_BITS)) : '0;
                force_set   = (wr_test && reg_wdata[FORCE_TRIG]) ? DATA_W'(FORCE_BITS) : '0;
                vector_code = '0;
            end

            // R11: the force write raises all six interrupt sources.
            a_r11_force_all: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_test && reg_wdata[FORCE_TRIG]) |=>
                    ((status & DATA_W'(FORCE_BITS)) == DATA_W'(FORCE_BITS)));

            // R10: a status write never clears a bit outside the clearable set.
            a_r10_w1c_scope: assert property (@(posedge clk) disable iff (!rst_n)
                wr_status |=> (($past(status) & ~$past(clr_pulse) & ~DATA_W'(W1C_BITS) & ~status) == '0));
        end else begin : g_old
            logic rd_vector;
            // Vector read acknowledges the lowest pending event; status is read-only.
            always_comb begin
                rd_vector   = reg_rd && (reg_addr == SEL_VECTOR);
                sw_clr      = (rd_vector && pend_any) ? (DATA_W'(1) << pend_idx) : '0;
                force_set   = '0;
                vector_code = pend_any ? (DATA_W'(pend_idx) + DATA_W'(1)) : '0;
            end

            // R8: the acknowledged bit is gone after the read unless re-set.
            a_r8_vector_acks: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_vector && pend_any && !set_pulse[pend_idx]) |=> !status[$past(pend_idx)]);

            // R10: a status write alone leaves status unchanged.
            a_r10_status_read_only: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_status && !reg_rd && (set_pulse == '0) && (clr_pulse == '0)) |=>
                    (status == $past(status)));
        end
    endgenerate

    // Status as seen by software: live bus-busy replaces the stored bit.
    always_comb begin
        status_view           = status;
        status_view[BUSY_BIT] = bus_busy;
    end

    // Read data mux, zero outside a read.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                SEL_MASK:   reg_rdata = mask;
                SEL_STATUS: reg_rdata = status_view;
                SEL_VECTOR: reg_rdata = vector_code;
                SEL_DMACFG: reg_rdata = dma_cfg;
                default:    reg_rdata = '0;
            endcase
        end
    end

    // Request lines straight from the stored registers.
    always_comb begin
        irq     = pend_any;
        dreq_rx = dma_cfg[RX_DMA_EN_BIT] & status[RX_READY_BIT];
        dreq_tx = dma_cfg[TX_DMA_EN_BIT] & status[TX_READY_BIT];
    end

    // R8: a reported vector always names a pending bit with none below it.
    a_r8_vector_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == SEL_VECTOR) && (reg_rdata != '0)) |->
            (pending[reg_rdata - 1] &&
             ((pending & ((DATA_W'(1) << (reg_rdata - 1)) - DATA_W'(1))) == '0)));

    // R5: a DMA request never stands without its ready flag.
    a_r5_dreq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_rx |-> status[RX_READY_BIT]) and (dreq_tx |-> status[TX_READY_BIT]));
endmodule

// File: tb/isd_irq_dma_unit_test.sv
// Bench: drives one newer-revision unit (uut) and one older-revision unit
// (uut_legacy) with the same stimulus and compares both against a
// behavioural model after every clock edge.
module isd_irq_dma_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] set_p = 16'h0;
    logic [15:0] clr_p = 16'h0;
    logic        busy = 1'b0;
    logic [15:0] rdata_n;
    logic [15:0] rdata_l;
    logic [1:0]  irq_v;
    logic [1:0]  drx_v;
    logic [1:0]  dtx_v;

    int    n_checks = 0;
    int    n_fail = 0;
    string phase = "R1 reset";

    // Model state: index 0 newer revision, index 1 older revision.
    logic [15:0] m_stat [2];
    logic [15:0] m_mask [2];
    logic [15:0] m_dma  [2];

    always #4 clk = ~clk;

    isd_irq_dma_unit #(.REVISION(8'h34)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_n),
        .set_pulse(set_p), .clr_pulse(clr_p), .bus_busy(busy),
        .irq(irq_v[0]), .dreq_rx(drx_v[0]), .dreq_tx(dtx_v[0])
    );

    isd_irq_dma_unit #(.REVISION(8'h20)) uut_legacy (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_l),
        .set_pulse(set_p), .clr_pulse(clr_p), .bus_busy(busy),
        .irq(irq_v[1]), .dreq_rx(drx_v[1]), .dreq_tx(dtx_v[1])
    );

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s (%s): actual %h expected %h", req, what, phase, act, exp);
        end
    endtask

    function automatic logic [15:0] vec_code(logic [15:0] p);
        for (int i = 0; i < 16; i++) if (p[i]) return 16'(i + 1);
        return 16'h0;
    endfunction

    function automatic logic [15:0] exp_rd(int k, bit rd, logic [2:0] a, bit bz);
        logic [15:0] v;
        if (!rd) return 16'h0;
        case (a)
            3'd0: v = m_mask[k];
            3'd1: begin v = m_stat[k]; v[12] = bz; end
            3'd2: v = (k == 1) ? vec_code(m_stat[k] & m_mask[k]) : 16'h0;
            3'd3: v = m_dma[k];
            default: v = 16'h0;
        endcase
        return v;
    endfunction

    function automatic string rd_req(logic [2:0] a);
        case (a)
            3'd0: return "R7";
            3'd1: return "R3";
            3'd2: return "R8";
            3'd3: return "R6";
            default: return "R9";
        endcase
    endfunction

    // One clock: drive at the falling edge, compare, advance the model, wait.
    task automatic step(bit wr, bit rd, logic [2:0] a, logic [15:0] wd,
                        logic [15:0] sp, logic [15:0] cp, bit bz);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        set_p = sp; clr_p = cp; busy = bz;
        #1;
        for (int k = 0; k < 2; k++) begin
            chk(rd_req(a), k == 0 ? "rdata new" : "rdata old",
                k == 0 ? rdata_n : rdata_l, exp_rd(k, rd, a, bz));
            chk("R4", "irq", 16'(irq_v[k]), 16'(|(m_stat[k] & m_mask[k])));
            chk("R5", "dreq_rx", 16'(drx_v[k]), 16'(m_dma[k][15] & m_stat[k][3]));
            chk("R5", "dreq_tx", 16'(dtx_v[k]), 16'(m_dma[k][7] & m_stat[k][4]));
        end
        for (int k = 0; k < 2; k++) begin
            logic [15:0] st;
            logic [15:0] p;
            st = m_stat[k];
            p  = st & m_mask[k];
            if (rd && a == 3'd2 && k == 1 && p != 16'h0) st[vec_code(p) - 1] = 1'b0;
            if (wr && a == 3'd1 && k == 0) st &= ~(wd & 16'h0027);
            st = (st & ~cp) | sp;
            if (wr && a == 3'd4 && k == 0 && wd[11]) st |= 16'h003f;
            m_stat[k] = st;
            if (wr && a == 3'd0) m_mask[k] = wd & ((k == 0) ? 16'h003f : 16'h001f);
            if (wr && a == 3'd3) begin
                m_dma[k] = wd & 16'h8080;
                if (wd[15]) m_mask[k][3] = 1'b0;
                if (wd[7])  m_mask[k][4] = 1'b0;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(logic [15:0] sp, logic [15:0] cp);
        step(1'b0, 1'b0, 3'd0, 16'h0, sp, cp, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_stat[k] = 16'h0; m_mask[k] = 16'h0; m_dma[k] = 16'h0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state at the ports before release.
        for (int k = 0; k < 2; k++) begin
            chk("R1", "irq reset", 16'(irq_v[k]), 16'h0);
            chk("R1", "dreq_rx reset", 16'(drx_v[k]), 16'h0);
            chk("R1", "dreq_tx reset", 16'(dtx_v[k]), 16'h0);
        end
        rst_n = 1'b1;
        step(1'b0, 1'b1, 3'd0, 16'h0, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd3, 16'h0, 16'h0, 16'h0, 1'b0);

        phase = "R2 set/clear pulses";
        idle(16'h001e, 16'h0);
        step(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 16'h0002, 1'b0);
        step(1'b0, 1'b1, 3'd1, 16'h0, 16'h0004, 16'h0004, 1'b0);
        step(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 16'h001c, 1'b0);

        phase = "R3 busy view";
        idle(16'h1000, 16'h0);
        step(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 16'h0, 1'b1);
        step(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 16'h1000, 1'b0);
        step(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 16'h0, 1'b1);

        phase = "R7 mask width / R4 irq";
        step(1'b1, 1'b0, 3'd0, 16'hffff, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd0, 16'h0, 16'h0020, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 16'h0020, 1'b0);
        step(1'b0, 1'b1, 3'd0, 16'h0, 16'h0001, 16'h0, 1'b0);
        idle(16'h0, 16'hffff);

        phase = "R6 DMA config / R5 requests";
        idle(16'h0018, 16'h0);
        step(1'b1, 1'b0, 3'd3, 16'hffff, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd3, 16'h0, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd0, 16'h0, 16'h0, 16'h0008, 1'b0);
        idle(16'h0, 16'h0010);
        step(1'b1, 1'b0, 3'd0, 16'h001f, 16'h0, 16'h0, 1'b0);
        step(1'b1, 1'b0, 3'd3, 16'h0080, 16'h0018, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd0, 16'h0, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd3, 16'h0, 16'h0, 16'h0, 1'b0);
        step(1'b1, 1'b0, 3'd3, 16'h0000, 16'h0, 16'hffff, 1'b0);

        phase = "R8 vector acknowledge";
        step(1'b1, 1'b0, 3'd0, 16'h0027, 16'h0, 16'h0, 1'b0);
        idle(16'h0016, 16'h0);
        step(1'b0, 1'b1, 3'd2, 16'h0, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd2, 16'h0, 16'h0, 16'h0, 1'b0);
        phase = "R9 empty vector";
        step(1'b0, 1'b1, 3'd2, 16'h0, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd4, 16'h0, 16'h0, 16'h0, 1'b0);
        phase = "R8 vector with set pulse";
        idle(16'h0001, 16'h0);
        step(1'b0, 1'b1, 3'd2, 16'h0, 16'h0001, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd2, 16'h0, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 16'hffff, 1'b0);

        phase = "R10 status write";
        idle(16'hefff, 16'h0);
        step(1'b1, 1'b0, 3'd1, 16'hffff, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 16'h0, 1'b0);
        step(1'b1, 1'b0, 3'd1, 16'h0010, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 16'hffff, 1'b0);

        phase = "R11 force interrupts";
        step(1'b1, 1'b0, 3'd4, 16'hf7ff, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 16'h0, 1'b0);
        step(1'b1, 1'b0, 3'd4, 16'h0800, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd1, 16'h0, 16'h0, 16'h0, 1'b0);
        step(1'b0, 1'b1, 3'd4, 16'h0, 16'h0, 16'hffff, 1'b0);

        phase = "R12 output latency";
        step(1'b1, 1'b0, 3'd0, 16'h0004, 16'h0, 16'h0, 1'b0);
        step(1'b1, 1'b0, 3'd3, 16'h8000, 16'h0004, 16'h0, 1'b0);
        idle(16'h0008, 16'h0004);
        idle(16'h0, 16'h0008);
        idle(16'h0, 16'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule